// File: doc/BRIEF.md
# Integer Add Execution Unit with Status Flags and Overflow Trap

This unit is the adding slice of a small RISC pipeline. Each issued operation sums a register operand with either a second register operand or a sign-extended 16-bit immediate. Depending on the opcode, the carry bit held in the unit's status register is also added in. The 32-bit result is registered. The carry and signed-overflow flags are rewritten from the full three-input sum.

The status register also holds an overflow-trap enable bit. When that bit is set and an add overflows in the signed sense, the unit raises a one-cycle range-exception request. In the same cycle it captures the program counter of the offending add in an exception-PC register. A special-register write port lets the surrounding core load the status bits directly.

Top module: `add_exec_unit`

## Requirements
- R1: The 2-bit `op_i` encodes the variant. Bit 0 set means the status carry is added in. Bit 1 set means the second operand is the immediate. The encodings are 0 reg+reg, 1 reg+reg+carry, 2 reg+imm, 3 reg+imm+carry. The result appears on `result_o` one clock after `add_vld_i` is sampled high.
- R2: Opcodes 0 and 2 yield the same result and flags whether the stored carry is 0 or 1 (1 + 2 = 3 with carry preset).
- R3: Opcodes 1 and 3 add the stored carry bit as a carry-in (0x40000000 + 0x3fffffff + 1 = 0x80000000).
- R4: Immediate variants sign-extend `imm_i` from 16 to 32 bits (0x8000 gives 0xffff8000, 0x7fff gives 0x00007fff) and ignore `src_b_i`.
- R5: Status bit 0 (carry) is loaded with the unsigned carry out of bit 31 of a + b + cin. For example, 0xffffffff + 0 + 1 gives 0 with carry 1 and overflow 0.
- R6: Status bit 1 (overflow) is loaded with two's-complement overflow of the full sum. For example, 0xc0000000 + 0xbfffffff + 1 gives 0x80000000 with overflow 0 and carry 1.
- R7: `range_exc_o` pulses high for exactly one cycle, in the same cycle as the flag update, when an add sets overflow while status bit 2 (trap enable) is 1. A carry alone never raises it, and it stays low while the enable is 0.
- R8: When a range exception is raised, `epc_o` loads the `pc_i` of that add. It holds its value at all other times.
- R9: An add that raises a range exception still writes `result_o` and both flags.
- R10: With `sr_we_i` high and no add, all three status bits load from `sr_wdata_i` at the next edge. If both occur in one cycle, carry and overflow come from the add, trap enable comes from the write, and the add uses the pre-write status.
- R11: While `rst_ni` is low, the result, status, exception request and exception PC are all zero.
- R12: In a cycle with neither an add nor a status write, the result, status and exception PC keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| add_vld_i | input | 1 | An add is issued this cycle |
| op_i | input | 2 | Add variant (see R1) |
| src_a_i | input | 32 | First register operand |
| src_b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate operand |
| pc_i | input | 32 | Address of the issued add |
| sr_we_i | input | 1 | Status register write strobe |
| sr_wdata_i | input | 3 | Status write data {trap enable, overflow, carry} |
| result_o | output | 32 | Registered sum |
| sr_o | output | 3 | Status register {trap enable, overflow, carry} |
| range_exc_o | output | 1 | Range-exception request pulse |
| epc_o | output | 32 | Captured address of the overflowing add |

## Verification
The bench builds the unit with its default widths: 32-bit data and addresses and a 16-bit immediate. At these widths the sign bit of the immediate, bit 31 carry-out and the 0x7fffffff/0x80000000 signed boundary fall exactly on the directed operand pairs. Directed sequences cover carry-in edge cases, trap gating, and the write/add collision. A long stretch of random opcodes, operands, immediates and status writes then runs against the cycle model.

// File: rtl/add_unit_pkg.sv
package add_unit_pkg;
  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_ADDC  = 2'd1,
    OP_ADDI  = 2'd2,
    OP_ADDIC = 2'd3
  } add_op_e;

  localparam int SR_CY  = 0;
  localparam int SR_OV  = 1;
  localparam int SR_OVE = 2;
  localparam int SR_W   = 3;
endpackage

// File: rtl/add_operand_sel.sv
module add_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] opb_o,
  output logic              cin_o
);
  logic [DATA_W-1:0] imm_ext;

  generate
    if (IMM_W < DATA_W) begin : g_sext
      assign imm_ext = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_full
      assign imm_ext = imm_i[DATA_W-1:0];
    end
  endgenerate

  assign opb_o = op_i[1] ? imm_ext : src_b_i;
  assign cin_o = op_i[0] & cy_i;
endmodule

// File: rtl/add_core.sv
module add_core #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cy_o,
  output logic              ov_o
);
  localparam int MSB = DATA_W - 1;
  logic [DATA_W:0] wide;

  assign wide  = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
  assign sum_o = wide[DATA_W-1:0];
  assign cy_o  = wide[DATA_W];
  // like-signed inputs with an opposite-signed sum
  assign ov_o  = (a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]);
endmodule

// File: rtl/add_status_reg.sv
module add_status_reg
  import add_unit_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_vld_i,
  input  logic              cy_i,
  input  logic              ov_i,
  input  logic              sr_we_i,
  input  logic [SR_W-1:0]   sr_wdata_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic [SR_W-1:0]   sr_o,
  output logic              exc_o,
  output logic [ADDR_W-1:0] epc_o
);
  logic [SR_W-1:0]   sr_q;
  logic              exc_q;
  logic [ADDR_W-1:0] epc_q;
  logic              exc_d;

  assign exc_d = add_vld_i & ov_i & sr_q[SR_OVE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      exc_q <= 1'b0;
      epc_q <= '0;
    end else begin
      if (add_vld_i) begin
        sr_q[SR_CY]  <= cy_i;
        sr_q[SR_OV]  <= ov_i;
        sr_q[SR_OVE] <= sr_we_i ? sr_wdata_i[SR_OVE] : sr_q[SR_OVE];
      end else if (sr_we_i) begin
        sr_q <= sr_wdata_i;
      end
      exc_q <= exc_d;
      if (exc_d) epc_q <= pc_i;
    end
  end

  assign sr_o  = sr_q;
  assign exc_o = exc_q;
  assign epc_o = epc_q;

  // R7
  exc_needs_ov_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_q |-> sr_q[SR_OV]);
  // R7
  exc_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_vld_i && !sr_q[SR_OVE]) |=> !exc_q);
  // R8
  epc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_q |-> $stable(epc_q));
  // R12
  sr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!add_vld_i && !sr_we_i) |=> $stable(sr_q));
endmodule

// File: rtl/add_exec_unit.sv
module add_exec_unit
  import add_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              add_vld_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              sr_we_i,
  input  logic [SR_W-1:0]   sr_wdata_i,
  output logic [DATA_W-1:0] result_o,
  output logic [SR_W-1:0]   sr_o,
  output logic              range_exc_o,
  output logic [ADDR_W-1:0] epc_o
);
  logic [DATA_W-1:0] opb;
  logic              cin;
  logic [DATA_W-1:0] sum;
  logic              cy;
  logic              ov;
  logic [DATA_W-1:0] result_q;
  logic [SR_W-1:0]   sr;

  add_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .op_i    (op_i),
    .src_b_i (src_b_i),
    .imm_i   (imm_i),
    .cy_i    (sr[SR_CY]),
    .opb_o   (opb),
    .cin_o   (cin)
  );

  add_core #(.DATA_W(DATA_W)) u_core (
    .a_i   (src_a_i),
    .b_i   (opb),
    .cin_i (cin),
    .sum_o (sum),
    .cy_o  (cy),
    .ov_o  (ov)
  );

  add_status_reg #(.ADDR_W(ADDR_W)) u_sr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .add_vld_i  (add_vld_i),
    .cy_i       (cy),
    .ov_i       (ov),
    .sr_we_i    (sr_we_i),
    .sr_wdata_i (sr_wdata_i),
    .pc_i       (pc_i),
    .sr_o       (sr),
    .exc_o      (range_exc_o),
    .epc_o      (epc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        result_q <= '0;
    else if (add_vld_i) result_q <= sum;
  end

  assign result_o = result_q;
  assign sr_o     = sr;

  // R2
  no_carry_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_vld_i && !op_i[0]) |-> !cin);
  // R4
  imm_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_vld_i && op_i[1]) |-> (opb[IMM_W-1:0] == imm_i));
  // R9
  exc_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_vld_i && ov && sr[SR_OVE]) |=> (range_exc_o && result_o == $past(sum)));
  // R12
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !add_vld_i |=> $stable(result_o));
endmodule

// File: tb/tb_add_exec_unit.sv
`timescale 1ns/1ps
module tb_add_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] a = '0, b = '0, pc = '0;
  logic [15:0] imm = '0;
  logic        we = 1'b0;
  logic [2:0]  wd = '0;
  logic [31:0] result;
  logic [2:0]  sr;
  logic        exc;
  logic [31:0] epc;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [31:0] m_res = '0;
  logic [2:0]  m_sr = '0;
  logic        m_exc = 1'b0;
  logic [31:0] m_epc = '0;

  always #2.5 clk = ~clk;

  add_exec_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .add_vld_i(vld), .op_i(op),
    .src_a_i(a), .src_b_i(b), .imm_i(imm), .pc_i(pc),
    .sr_we_i(we), .sr_wdata_i(wd),
    .result_o(result), .sr_o(sr), .range_exc_o(exc), .epc_o(epc)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(tag, "result", result, m_res);
    check(tag, "status", {29'd0, sr}, {29'd0, m_sr});
    check(tag, "range_exc", {31'd0, exc}, {31'd0, m_exc});
    check(tag, "epc", epc, m_epc);
  endtask

  // behavioural model of one clock edge
  task automatic model_edge();
    longint      sa, sb, ssum;
    logic [63:0] usum;
    logic [31:0] opb;
    logic        cin, ov, cy;
    if (vld) begin
      opb  = op[1] ? {{16{imm[15]}}, imm} : b;
      cin  = op[0] ? m_sr[0] : 1'b0;
      usum = {32'd0, a} + {32'd0, opb} + {63'd0, cin};
      sa   = longint'($signed(a));
      sb   = longint'($signed(opb));
      ssum = sa + sb + longint'(cin);
      ov   = (ssum > 64'sd2147483647) || (ssum < -64'sd2147483648);
      cy   = usum[32];
      m_exc = ov && m_sr[2];
      if (m_exc) m_epc = pc;
      m_res = usum[31:0];
      m_sr  = {we ? wd[2] : m_sr[2], ov, cy};
    end else begin
      m_exc = 1'b0;
      if (we) m_sr = wd;
    end
  endtask

  task automatic step(bit v, logic [1:0] o, logic [31:0] xa, logic [31:0] xb,
                      logic [15:0] xi, logic [31:0] xpc, bit w, logic [2:0] xwd,
                      string tag);
    vld = v; op = o; a = xa; b = xb; imm = xi; pc = xpc; we = w; wd = xwd;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    vld = 1'b0; we = 1'b0;
    compare_all(tag);
  endtask

  task automatic wr_sr(logic [2:0] v, string tag);
    step(0, 2'd0, 32'h0, 32'h0, 16'h0, 32'h0, 1, v, tag);
  endtask

  task automatic idle(string tag);
    step(0, 2'd0, 32'hdeadbeef, 32'hcafef00d, 16'h5555, 32'hffff0000, 0, 3'b0, tag);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R11");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R11");

    // R10 plain write, R2 carry ignored
    wr_sr(3'b001, "R10");
    step(1, 2'd0, 32'd1, 32'd2, 16'h0, 32'h10, 0, 3'b0, "R2");
    wr_sr(3'b001, "R10");
    step(1, 2'd2, 32'd1, 32'h0, 16'h0002, 32'h14, 0, 3'b0, "R2");
    // R1 reg+reg forms
    step(1, 2'd0, 32'h40000000, 32'h3fffffff, 16'h0, 32'h18, 0, 3'b0, "R1");
    step(1, 2'd0, 32'hbfffffff, 32'hbfffffff, 16'h0, 32'h1c, 0, 3'b0, "R6");
    // R3 carry-in forms
    wr_sr(3'b001, "R10");
    step(1, 2'd1, 32'h40000000, 32'h3fffffff, 16'h0, 32'h20, 0, 3'b0, "R3");
    wr_sr(3'b001, "R10");
    step(1, 2'd1, 32'hffffffff, 32'h00000000, 16'h0, 32'h24, 0, 3'b0, "R5");
    step(1, 2'd1, 32'h00000000, 32'hffffffff, 16'h0, 32'h28, 0, 3'b0, "R5");
    step(1, 2'd1, 32'hc0000000, 32'hbfffffff, 16'h0, 32'h2c, 0, 3'b0, "R6");
    // R4 immediate sign extension, src_b ignored
    step(1, 2'd2, 32'h80008000, 32'h12345678, 16'h8000, 32'h30, 0, 3'b0, "R4");
    step(1, 2'd2, 32'hffffffff, 32'h0badf00d, 16'hfffe, 32'h34, 0, 3'b0, "R4");
    step(1, 2'd2, 32'h7fff8000, 32'hffffffff, 16'h7fff, 32'h38, 0, 3'b0, "R4");
    wr_sr(3'b001, "R10");
    step(1, 2'd3, 32'h7fff8000, 32'h0, 16'h7fff, 32'h3c, 0, 3'b0, "R3");
    wr_sr(3'b001, "R10");
    step(1, 2'd3, 32'h00000000, 32'h0, 16'hffff, 32'h40, 0, 3'b0, "R5");
    idle("R12");
    idle("R12");
    // R7 trap disabled: overflow gives no request
    step(1, 2'd0, 32'h40000000, 32'h40000000, 16'h0, 32'h44, 0, 3'b0, "R7");
    // enable trap
    wr_sr(3'b100, "R10");
    step(1, 2'd0, 32'h40000000, 32'h40000000, 16'h0, 32'h1000, 0, 3'b0, "R8");
    idle("R7");
    idle("R8");
    step(1, 2'd0, 32'hffffffff, 32'hfffffffe, 16'h0, 32'h2000, 0, 3'b0, "R7");
    step(1, 2'd0, 32'hbfffffff, 32'hbfffffff, 16'h0, 32'h3000, 0, 3'b0, "R9");
    step(1, 2'd0, 32'hbfffffff, 32'hbfffffff, 16'h0, 32'h3004, 0, 3'b0, "R7");
    step(1, 2'd3, 32'h7fffc000, 32'h0, 16'h3fff, 32'h3008, 0, 3'b0, "R9");
    // R10 collision: add flags win, OVE from write
    step(1, 2'd0, 32'h40000000, 32'h40000000, 16'h0, 32'h4000, 1, 3'b011, "R10");
    step(1, 2'd0, 32'h40000000, 32'h40000000, 16'h0, 32'h4004, 1, 3'b100, "R10");
    step(1, 2'd0, 32'h40000000, 32'h40000000, 16'h0, 32'h4008, 0, 3'b000, "R7");

    for (int i = 0; i < 2000; i++) begin
      step(($urandom % 4) != 0, 2'($urandom), $urandom, $urandom, 16'($urandom),
           $urandom, ($urandom % 6) == 0, 3'($urandom), "R1");
    end
    finish_run();
  end
endmodule